// File: doc/BRIEF.md
# Quadword and Per-Byte Vector Shifter

This block shifts a 128-bit vector in one of two ways. In quadword mode the whole vector moves as one value. It can shift left logically, right logically or right arithmetically, by a count from 0 to 127. In per-byte mode each of the sixteen bytes moves by its own amount of 0 to 7. The bits that enter a byte come from the adjacent byte of the same source vector, not from zero. Every byte result is formed from the unmodified source, so the bytes do not depend on one another.

Bits are numbered so that byte 0 is the most significant byte, bits 127:120. Byte 15 is bits 7:0. Bit 127 is the sign bit.

A request is presented with `in_valid`. Its result appears on `result`, together with `out_valid`, after the next rising clock edge. The result register keeps its value until the next request.

Top module: `vec_shifter`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `result` is all zeros until the first request.
- R2: A request with `in_valid`=1 at a rising edge gives `out_valid`=1 and its result after that edge. A cycle with `in_valid`=0 gives `out_valid`=0 after the edge, and `result` keeps its previous value.
- R3: `op`=0 (quad left) gives `operand` shifted left by `count` (0..127), with zeros entering at bit 0. A count of 0 returns the operand unchanged.
- R4: `op`=1 (quad logical right) gives `operand` shifted right by `count`, with zeros entering at bit 127. A count of 64 moves the upper doubleword into bits 63:0 and clears bits 127:64.
- R5: `op`=2 (quad arithmetic right) shifts right by `count` and fills every vacated bit with bit 127 of the operand.
- R6: In per-byte modes the amount for byte i is bits 2:0 of byte i of `amounts`; bits 7:3 of each amount byte have no effect.
- R7: `op`=4 (byte left) shifts byte i left by its amount. The bits that enter at its low end are the top bits of byte i+1 (the next less significant byte). Zeros enter byte 15.
- R8: `op`=5 (byte logical right) shifts byte i right by its amount. The bits that enter at its high end are the low bits of byte i-1. Zeros enter byte 0.
- R9: `op`=6 (byte arithmetic right) behaves as `op`=5, except that copies of bit 127 enter byte 0.
- R10: The reserved codes `op`=3 and `op`=7 produce an all-zero result with `out_valid`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation: 0 quad left, 1 quad logical right, 2 quad arithmetic right, 4 byte left, 5 byte logical right, 6 byte arithmetic right |
| operand | input | 128 | Source vector, byte 0 in bits 127:120 |
| count | input | 7 | Quadword shift count |
| amounts | input | 128 | Per-byte amounts, low 3 bits of each byte used |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Registered shift result |

## Verification
Every result is due exactly one rising edge after its request. The bench drives each request on a falling edge and reads `out_valid` and `result` at the next falling edge, half a period after the capturing edge.

The bench sweeps all 128 counts for every quadword operation over several operand patterns. It applies every uniform per-byte amount, and mixed per-byte amounts, with garbage in the upper amount bits. Idle cycles are checked at the next falling edge, to confirm that `out_valid` drops and `result` keeps its value.

// File: rtl/vec_shifter.sv
module vec_shifter #(
  parameter int NBYTES = 16,
  localparam int W = NBYTES * 8,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [W-1:0]  operand,
  input  logic [CW-1:0] count,
  input  logic [W-1:0]  amounts,
  output logic          out_valid,
  output logic [W-1:0]  result
);

  logic [W-1:0] quad_res;
  logic [W-1:0] byte_res;
  logic         sign;

  assign sign = operand[W-1];

  always_comb begin
    case (op[1:0])
      2'd0:    quad_res = operand << count;
      2'd1:    quad_res = operand >> count;
      2'd2:    quad_res = W'($signed(operand) >>> count);
      default: quad_res = '0;
    endcase
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam int H = W - 1 - 8 * i;
    logic [7:0]  cur, nxt, prv;
    logic [2:0]  sh;
    logic [15:0] lcat, rcat;

    assign cur = operand[H -: 8];
    assign sh  = amounts[H-5 -: 3];

    if (i == NBYTES - 1) begin : g_last
      assign nxt = 8'h00;
    end else begin : g_mid
      assign nxt = operand[H-8 -: 8];
    end

    if (i == 0) begin : g_first
      assign prv = op[1] ? {8{sign}} : 8'h00;
    end else begin : g_rest
      assign prv = operand[H+8 -: 8];
    end

    assign lcat = {cur, nxt} << sh;
    assign rcat = {prv, cur} >> sh;

    assign byte_res[H -: 8] = (op[1:0] == 2'd0) ? lcat[15:8] :
                              (op[1:0] == 2'd3) ? 8'h00 : rcat[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= op[2] ? byte_res : quad_res;
    end
  end

endmodule

// File: rtl/vec_shifter_chk.sv
module vec_shifter_chk #(
  parameter int NBYTES = 16,
  localparam int W = NBYTES * 8,
  localparam int CW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    op,
  input logic [W-1:0]  operand,
  input logic [CW-1:0] count,
  input logic [W-1:0]  amounts,
  input logic          out_valid,
  input logic [W-1:0]  result
);

  logic amt_zero;
  always_comb begin
    amt_zero = 1'b1;
    for (int i = 0; i < NBYTES; i++)
      if (amounts[8*i +: 3] != 3'd0) amt_zero = 1'b0;
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R2
  AST_QUAD_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[2:1] == 2'b00 && count == '0) |=> result == $past(operand)); // R3
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2) |=> result[W-1] == $past(operand[W-1])); // R5
  AST_BYTE_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[2] && op[1:0] != 2'd3 && amt_zero) |=> result == $past(operand)); // R6
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[1:0] == 2'd3) |=> result == '0); // R10

endmodule

bind vec_shifter vec_shifter_chk #(.NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .operand(operand),
  .count(count), .amounts(amounts), .out_valid(out_valid), .result(result)
);

// File: tb/sim_vec_shifter.sv
`timescale 1ns/1ps
module sim_vec_shifter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   op = 3'd0;
  logic [127:0] operand = '0;
  logic [6:0]   count = '0;
  logic [127:0] amounts = '0;
  logic         out_valid;
  logic [127:0] result;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  vec_shifter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .operand(operand),
    .count(count), .amounts(amounts), .out_valid(out_valid), .result(result)
  );

  function automatic logic [127:0] exp_quad(input logic [2:0] o, input logic [127:0] a, input int c);
    logic [127:0] r = '0;
    for (int j = 0; j < 128; j++) begin
      case (o)
        3'd0: r[j] = (j >= c) ? a[j-c] : 1'b0;
        3'd1: r[j] = (j + c <= 127) ? a[j+c] : 1'b0;
        3'd2: r[j] = (j + c <= 127) ? a[j+c] : a[127];
        default: r[j] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [127:0] exp_byte(input logic [2:0] o, input logic [127:0] a, input logic [127:0] m);
    logic [127:0] r = '0;
    for (int g = 0; g < 128; g++) begin
      int s = int'(m[120 - 8*(g/8) +: 3]);
      int src;
      if (o == 3'd4) begin
        src = g + s;
        r[127-g] = (src <= 127) ? a[127-src] : 1'b0;
      end else if (o == 3'd5 || o == 3'd6) begin
        src = g - s;
        r[127-g] = (src >= 0) ? a[127-src] : ((o == 3'd6) ? a[127] : 1'b0);
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run_quad(input logic [2:0] o, input logic [127:0] a, input int c, input string tag);
    op = o; operand = a; count = 7'(c); amounts = {$urandom, $urandom, $urandom, $urandom};
    in_valid = 1'b1;
    @(negedge clk);
    check("R2 valid", {127'b0, out_valid}, 128'd1);
    check(tag, result, exp_quad(o, a, c));
  endtask

  task automatic run_byte(input logic [2:0] o, input logic [127:0] a, input logic [127:0] m, input string tag);
    op = o; operand = a; amounts = m; count = 7'($urandom);
    in_valid = 1'b1;
    @(negedge clk);
    check("R2 valid", {127'b0, out_valid}, 128'd1);
    check(tag, result, exp_byte(o, a, m));
  endtask

  task automatic idle_check();
    logic [127:0] held = result;
    in_valid = 1'b0;
    operand = ~operand; op = 3'd4; count = count + 7'd1;
    @(negedge clk);
    check("R2 idle valid", {127'b0, out_valid}, 128'd0);
    check("R2 idle hold", result, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [127:0] pats [4];
    string qtag [3];
    void'($urandom(7));
    pats[0] = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
    pats[1] = 128'h80000000000000000000000000000001;
    pats[2] = {4{32'hA5C3_5A3C}};
    pats[3] = {$urandom, $urandom, $urandom, $urandom};
    qtag[0] = "R3 quad left";
    qtag[1] = "R4 quad logical right";
    qtag[2] = "R5 quad arith right";

    repeat (3) @(negedge clk);
    check("R1 reset valid", {127'b0, out_valid}, 128'd0);
    check("R1 reset result", result, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", result, 128'd0);

    for (int o = 0; o < 3; o++)
      for (int p = 0; p < 4; p++)
        for (int c = 0; c < 128; c++)
          run_quad(3'(o), pats[p], c, qtag[o]);

    run_quad(3'd1, pats[0], 64, "R4 count 64");
    check("R4 count 64 upper zero", {64'b0, result[127:64]}, 128'd0);
    run_quad(3'd2, pats[1], 64, "R5 count 64 sign");
    check("R5 count 64 upper ones", {64'b0, result[127:64]}, {64'b0, {64{1'b1}}});
    idle_check();

    for (int o = 4; o < 7; o++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 8; s++) begin
          logic [127:0] m;
          for (int b = 0; b < 16; b++) m[8*b +: 8] = {5'($urandom), 3'(s)};
          run_byte(3'(o), pats[p], m, (o == 4) ? "R7 R6 byte left" : (o == 5) ? "R8 R6 byte logical right" : "R9 R6 byte arith right");
        end

    for (int o = 4; o < 7; o++)
      for (int k = 0; k < 60; k++) begin
        logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
        logic [127:0] m = {$urandom, $urandom, $urandom, $urandom};
        if (k == 0) a[127] = 1'b1;
        run_byte(3'(o), a, m, (o == 4) ? "R7 mixed" : (o == 5) ? "R8 mixed" : "R9 mixed");
      end
    idle_check();

    run_byte(3'd6, 128'h80FF00000000000000000000000000FF, {16{8'hFF}}, "R9 sign byte0");
    run_byte(3'd4, 128'h00000000000000000000000000000081, {16{8'h07}}, "R7 byte15 zero fill");
    run_byte(3'd5, 128'h81000000000000000000000000000000, {16{8'h07}}, "R8 byte0 zero fill");

    run_quad(3'd3, pats[0], 5, "R10 reserved 3");
    run_byte(3'd7, pats[0], {16{8'h03}}, "R10 reserved 7");
    idle_check();

    in_valid = 1'b0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule